// File: doc/BRIEF.md
# Return instruction execution unit

This unit carries out the two return opcodes of a small 8-bit accumulator processor: return-with-literal and return-from-interrupt. It owns the hardware return-address stack. Each return pops the top entry into the program counter. Return-with-literal also loads an 8-bit constant into the working register W. Return-from-interrupt re-arms one interrupt enable. When its fast flag is set, it also copies the shadow values of W, STATUS and BSR back into those registers. Any other instruction word is consumed and has no effect.

Instruction words arrive on a valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. Together with the word, the unit captures the shadow inputs and the interrupt-priority inputs on that same edge. While `in_ready` is low, the source must hold its word. No word is lost or taken twice under back-pressure.

Each return lasts two instruction cycles of four phases each, one clock per phase. Acceptance is phase Q1 of the first cycle. The results commit at Q4 of that cycle. The second cycle does nothing. Return addresses are written into the stack from outside through a plain push port.

Top module: `ret_unit`

## Requirements
- R1: After reset, `pc`, `w`, `status` and `bsr` are zero. `underflow`, `pc_load`, `ie_set_hi` and `ie_set_lo` are low, `in_ready` is high and the stack is empty.
- R2: A word whose bits [15:8] equal 0x0C is return-with-literal. At commit, `w` takes bits [7:0] of the word, `pc` takes the popped address, `status` and `bsr` do not change, and neither enable strobe pulses.
- R3: A word whose bits [15:1] equal 0x0008 is return-from-interrupt, and bit 0 is the fast flag. At commit, `pc` takes the popped address. If the flag is 1, `w`, `status` and `bsr` take the shadow inputs captured at acceptance. If the flag is 0, those three registers keep their values.
- R4: At the commit of return-from-interrupt, exactly one strobe pulses for one cycle. With `prio_mode` low, `ie_set_hi` pulses; it stands for the single global enable. With `prio_mode` high, `ie_set_hi` pulses if `hi_active` was high at acceptance, and `ie_set_lo` pulses otherwise.
- R5: For a return accepted on edge e0, the outputs and the one-cycle `pc_load` pulse change on edge e0+3. `in_ready` is low from e0 until edge e0+7 raises it again, and no other word is taken in that window.
- R6: Any word that is neither return form is accepted, leaves `in_ready` high, and changes no output or stack entry.
- R7: While `push_en` is high on an edge, `push_addr` goes on top of the stack, and pops return entries last-in first-out. A push arriving while 31 entries are held is dropped.
- R8: A pop on an empty stack sets `pc` to 0 and sets `underflow`. The stack stays empty. `underflow` stays set until reset.
- R9: A push on the commit edge takes effect after the pop. On a non-empty stack, `pc` takes the old top, the pushed address becomes the new top, and the depth is unchanged. On an empty stack, underflow applies and the pushed address becomes the only entry. On a full stack, the push is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per Q phase |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word |
| in_word | input | 16 | Instruction word |
| shadow_w | input | 8 | Shadow copy of W |
| shadow_status | input | 5 | Shadow copy of STATUS |
| shadow_bsr | input | 4 | Shadow copy of BSR |
| prio_mode | input | 1 | Two-level interrupt priority enabled |
| hi_active | input | 1 | High-priority handler is running |
| push_en | input | 1 | Write an address onto the stack |
| push_addr | input | 21 | Address to push |
| pc | output | 21 | Program counter loaded by a return |
| pc_load | output | 1 | One-cycle pulse when pc was loaded |
| w | output | 8 | Working register |
| status | output | 5 | Status register |
| bsr | output | 4 | Bank-select register |
| ie_set_hi | output | 1 | Pulse: set the high (or global) interrupt enable |
| ie_set_lo | output | 1 | Pulse: set the low interrupt enable |
| underflow | output | 1 | Sticky: a pop found the stack empty |

## Verification
The stack pop from a return and an external push can land on the same edge. The bench provokes this by raising `push_en` on exactly the Q4 commit edge of a return, once on a non-empty stack, once on an empty one and during random runs. It judges the result by checking that `pc` holds the old top. It then pops again and confirms that the pushed address comes back while the depth is kept.

// File: rtl/ret_pkg.sv
package ret_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LITRET = 2'd1,
    OP_INTRET = 2'd2
  } ret_op_e;

  localparam logic [7:0]  LITRET_HI = 8'h0C;
  localparam logic [14:0] INTRET_HI = 15'h0008;

  function automatic ret_op_e classify(input logic [15:0] iw);
    if (iw[15:8] == LITRET_HI)      return OP_LITRET;
    else if (iw[15:1] == INTRET_HI) return OP_INTRET;
    else                            return OP_NONE;
  endfunction
endpackage

// File: rtl/ret_decode.sv
module ret_decode
  import ret_pkg::*;
(
  input  logic [15:0] iw,
  output ret_op_e     op,
  output logic        fast,
  output logic [7:0]  lit
);
  always_comb begin
    op   = classify(iw);
    fast = iw[0];
    lit  = iw[7:0];
  end
endmodule

// File: rtl/ret_seq.sv
module ret_seq #(
  parameter int PHASES = 4,
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic is_ret,
  output logic in_ready,
  output logic accept,
  output logic commit
);
  localparam int TOTAL = PHASES * CYCLES;
  localparam int PH_W  = $clog2(TOTAL);
  localparam logic [PH_W-1:0] COMMIT_PH = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] LAST_PH   = PH_W'(TOTAL - 1);

  logic            busy;
  logic [PH_W-1:0] ph;

  always_comb begin
    in_ready = !busy;
    accept   = in_valid && in_ready;
    commit   = busy && (ph == COMMIT_PH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (!busy) begin
      if (accept && is_ret) begin
        busy <= 1'b1;
        ph   <= PH_W'(1);
      end
    end else if (ph == LAST_PH) begin
      busy <= 1'b0;
      ph   <= '0;
    end else begin
      ph <= ph + PH_W'(1);
    end
  end

  p_ready_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ret) |=> !in_ready);
  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
  p_commit_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 31,
  parameter int AW    = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] pop_addr,
  output logic          empty
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [AW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] ptr, ptr_mid, ptr_nxt, top_idx;
  logic             do_pop, do_push;

  always_comb begin
    empty    = (ptr == '0);
    top_idx  = ptr - PTR_W'(1);
    pop_addr = empty ? '0 : mem[top_idx[IDX_W-1:0]];
    do_pop   = pop && !empty;
    ptr_mid  = do_pop ? top_idx : ptr;
    do_push  = push && (ptr_mid != FULL);
    ptr_nxt  = do_push ? ptr_mid + PTR_W'(1) : ptr_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[ptr_mid[IDX_W-1:0]] <= push_addr;
  end

  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= FULL);
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && ptr == FULL) |=> (ptr == FULL));
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
  p_swap_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push && !empty) |=> $stable(ptr));
endmodule

// File: rtl/ret_unit.sv
module ret_unit
  import ret_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int DATA_W = 8,
  parameter int STS_W  = 5,
  parameter int BSR_W  = 4,
  parameter int DEPTH  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_word,
  input  logic [DATA_W-1:0] shadow_w,
  input  logic [STS_W-1:0]  shadow_status,
  input  logic [BSR_W-1:0]  shadow_bsr,
  input  logic              prio_mode,
  input  logic              hi_active,
  input  logic              push_en,
  input  logic [PC_W-1:0]   push_addr,
  output logic [PC_W-1:0]   pc,
  output logic              pc_load,
  output logic [DATA_W-1:0] w,
  output logic [STS_W-1:0]  status,
  output logic [BSR_W-1:0]  bsr,
  output logic              ie_set_hi,
  output logic              ie_set_lo,
  output logic              underflow
);
  ret_op_e           dec_op, op_q;
  logic              dec_fast, fast_q, lvl_hi_q;
  logic [7:0]        dec_lit, lit_q;
  logic [DATA_W-1:0] ws_q;
  logic [STS_W-1:0]  ss_q;
  logic [BSR_W-1:0]  bs_q;
  logic              accept, commit, stk_empty;
  logic [PC_W-1:0]   pop_addr;

  ret_decode u_dec (
    .iw   (in_word),
    .op   (dec_op),
    .fast (dec_fast),
    .lit  (dec_lit)
  );

  ret_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .is_ret   (dec_op != OP_NONE),
    .in_ready (in_ready),
    .accept   (accept),
    .commit   (commit)
  );

  ret_stack #(.DEPTH(DEPTH), .AW(PC_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_en),
    .push_addr (push_addr),
    .pop       (commit),
    .pop_addr  (pop_addr),
    .empty     (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      fast_q   <= 1'b0;
      lit_q    <= '0;
      ws_q     <= '0;
      ss_q     <= '0;
      bs_q     <= '0;
      lvl_hi_q <= 1'b1;
    end else if (accept && dec_op != OP_NONE) begin
      op_q     <= dec_op;
      fast_q   <= dec_fast;
      lit_q    <= dec_lit;
      ws_q     <= shadow_w;
      ss_q     <= shadow_status;
      bs_q     <= shadow_bsr;
      lvl_hi_q <= !prio_mode || hi_active;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      pc_load   <= 1'b0;
      w         <= '0;
      status    <= '0;
      bsr       <= '0;
      ie_set_hi <= 1'b0;
      ie_set_lo <= 1'b0;
      underflow <= 1'b0;
    end else begin
      pc_load   <= commit;
      ie_set_hi <= commit && (op_q == OP_INTRET) && lvl_hi_q;
      ie_set_lo <= commit && (op_q == OP_INTRET) && !lvl_hi_q;
      if (commit) begin
        pc <= pop_addr;
        if (stk_empty) underflow <= 1'b1;
        if (op_q == OP_LITRET) begin
          w <= DATA_W'(lit_q);
        end else if (fast_q) begin
          w      <= ws_q;
          status <= ss_q;
          bsr    <= bs_q;
        end
      end
    end
  end

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ie_set_hi, ie_set_lo}));
  p_strobe_at_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set_hi || ie_set_lo) |-> pc_load);
  p_w_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |-> ($stable(w) && $stable(pc) && $stable(status) && $stable(bsr)));
  p_litret_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !ie_set_hi && !ie_set_lo) |-> ($stable(status) && $stable(bsr)));
  p_sticky_uf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

// File: tb/ret_unit_tb.sv
`timescale 1ns/1ps
module ret_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [7:0]  shadow_w = '0;
  logic [4:0]  shadow_status = '0;
  logic [3:0]  shadow_bsr = '0;
  logic        prio_mode = 1'b0;
  logic        hi_active = 1'b0;
  logic        push_en = 1'b0;
  logic [20:0] push_addr = '0;
  logic [20:0] pc;
  logic        pc_load, ie_set_hi, ie_set_lo, underflow;
  logic [7:0]  w;
  logic [4:0]  status;
  logic [3:0]  bsr;

  always #5 clk = ~clk;

  ret_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .shadow_w(shadow_w), .shadow_status(shadow_status),
    .shadow_bsr(shadow_bsr), .prio_mode(prio_mode), .hi_active(hi_active),
    .push_en(push_en), .push_addr(push_addr), .pc(pc), .pc_load(pc_load),
    .w(w), .status(status), .bsr(bsr), .ie_set_hi(ie_set_hi),
    .ie_set_lo(ie_set_lo), .underflow(underflow)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [20:0] m_stk [32];
  int          m_cnt = 0;
  logic [20:0] m_pc = '0;
  logic [7:0]  m_w = '0;
  logic [4:0]  m_sts = '0;
  logic [3:0]  m_bsr = '0;
  bit          m_uf = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_lit(input logic [15:0] iw);
    return iw[15:8] == 8'h0C;
  endfunction
  function automatic bit is_int(input logic [15:0] iw);
    return iw[15:1] == 15'h0008;
  endfunction

  function automatic void m_push(input logic [20:0] a);
    if (m_cnt < 31) begin
      m_stk[m_cnt] = a;
      m_cnt++;
    end
  endfunction

  function automatic logic [20:0] m_pop();
    if (m_cnt == 0) begin
      m_uf = 1;
      return '0;
    end
    m_cnt--;
    return m_stk[m_cnt];
  endfunction

  task automatic push(input logic [20:0] a);
    @(negedge clk);
    push_en = 1'b1;
    push_addr = a;
    @(posedge clk);
    @(negedge clk);
    push_en = 1'b0;
    m_push(a);
  endtask

  task automatic run_op(input logic [15:0] iw, input logic [7:0] sw,
                        input logic [4:0] ss, input logic [3:0] sb,
                        input bit pm, input bit ha,
                        input bit dp, input logic [20:0] pv);
    bit exp_hi, exp_lo;
    @(negedge clk);
    in_valid = 1'b1; in_word = iw; shadow_w = sw; shadow_status = ss;
    shadow_bsr = sb; prio_mode = pm; hi_active = ha;
    chk(in_ready == 1'b1, "R5", "ready before accept", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_word = $urandom();
    if (!is_lit(iw) && !is_int(iw)) begin
      chk(in_ready == 1'b1, "R6", "ready after ignored word", in_ready, 1);
      chk(pc_load == 1'b0, "R6", "no load on ignored word", pc_load, 0);
      chk(w == m_w && pc == m_pc, "R6", "w/pc unchanged", {pc, w}, {m_pc, m_w});
      return;
    end
    chk(in_ready == 1'b0, "R5", "ready low after accept", in_ready, 0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pc_load == 1'b0, "R5", "no early commit", pc_load, 0);
    @(posedge clk);
    @(negedge clk);
    if (dp) begin push_en = 1'b1; push_addr = pv; end
    @(posedge clk);
    @(negedge clk);
    push_en = 1'b0;
    m_pc = m_pop();
    if (dp) m_push(pv);
    if (is_lit(iw)) m_w = iw[7:0];
    else if (iw[0]) begin m_w = sw; m_sts = ss; m_bsr = sb; end
    exp_hi = is_int(iw) && (!pm || ha);
    exp_lo = is_int(iw) && pm && !ha;
    chk(pc_load == 1'b1, "R5", "pc_load at Q4", pc_load, 1);
    chk(pc == m_pc, dp ? "R9" : (m_uf ? "R8" : "R7"), "pc after pop", pc, m_pc);
    chk(w == m_w, is_lit(iw) ? "R2" : "R3", "w", w, m_w);
    chk(status == m_sts, is_lit(iw) ? "R2" : "R3", "status", status, m_sts);
    chk(bsr == m_bsr, is_lit(iw) ? "R2" : "R3", "bsr", bsr, m_bsr);
    chk(ie_set_hi == exp_hi, "R4", "ie_set_hi", ie_set_hi, exp_hi);
    chk(ie_set_lo == exp_lo, "R4", "ie_set_lo", ie_set_lo, exp_lo);
    chk(underflow == m_uf, "R8", "underflow", underflow, m_uf);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R5", "ready still low in cycle 2", in_ready, 0);
    chk(ie_set_hi == 1'b0 && ie_set_lo == 1'b0, "R4", "strobe one cycle",
        {ie_set_hi, ie_set_lo}, 0);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R5", "ready back after e0+7", in_ready, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(pc == 0 && w == 0 && status == 0 && bsr == 0, "R1", "regs zero",
        {pc, w, status, bsr}, 0);
    chk(!underflow && !pc_load && !ie_set_hi && !ie_set_lo, "R1", "flags low",
        {underflow, pc_load, ie_set_hi, ie_set_lo}, 0);
    chk(in_ready == 1'b1, "R1", "ready high", in_ready, 1);

    // R8 pop on empty stack
    run_op(16'h0C5A, 8'h00, 5'h00, 4'h0, 0, 0, 0, '0);
    // R7 LIFO, R2 literal return, R3 slow return, R4 global enable
    push(21'h012345);
    push(21'h0ABCDE);
    run_op(16'h0CA7, 8'h11, 5'h1F, 4'hF, 0, 0, 0, '0);
    run_op(16'h0010, 8'h22, 5'h15, 4'h9, 0, 1, 0, '0);
    // R3 fast return with shadows, R4 priority levels
    push(21'h1FFFFF);
    push(21'h000444);
    push(21'h000555);
    run_op(16'h0011, 8'hC3, 5'h0A, 4'h6, 1, 0, 0, '0);
    run_op(16'h0011, 8'h3C, 5'h15, 4'h9, 1, 1, 0, '0);
    run_op(16'h0010, 8'h99, 5'h1B, 4'h2, 1, 0, 0, '0);
    // R6 words that are not returns
    run_op(16'h0012, 8'h00, 5'h00, 4'h0, 0, 0, 0, '0);
    run_op(16'h0D55, 8'h00, 5'h00, 4'h0, 0, 0, 0, '0);
    run_op(16'h8C00, 8'h00, 5'h00, 4'h0, 0, 0, 0, '0);
    // R9 push on the commit edge, non-empty then empty stack
    push(21'h000777);
    run_op(16'h0C01, 8'h00, 5'h00, 4'h0, 0, 0, 1, 21'h000888);
    run_op(16'h0C02, 8'h00, 5'h00, 4'h0, 0, 0, 0, '0);
    run_op(16'h0010, 8'h00, 5'h00, 4'h0, 1, 1, 1, 21'h000999);
    run_op(16'h0C03, 8'h00, 5'h00, 4'h0, 0, 0, 0, '0);
    // R7 fill past capacity, last push dropped, then drain
    for (int i = 0; i < 32; i++) push(21'(32'h100 + i));
    run_op(16'h0C04, 8'h00, 5'h00, 4'h0, 0, 0, 1, 21'h0AAAAA);
    for (int i = 0; i < 32; i++)
      run_op(16'h0C00 | 16'(i), 8'h00, 5'h00, 4'h0, 0, 0, 0, '0);

    // random mix
    for (int it = 0; it < 80; it++) begin
      int np, k;
      logic [15:0] iw;
      np = $urandom_range(0, 2);
      for (int j = 0; j < np; j++) push(21'($urandom()));
      k = $urandom_range(0, 3);
      case (k)
        0: iw = {8'h0C, 8'($urandom())};
        1: iw = 16'h0010;
        2: iw = 16'h0011;
        default: iw = 16'($urandom());
      endcase
      run_op(iw, 8'($urandom()), 5'($urandom()), 4'($urandom()),
             1'($urandom()), 1'($urandom()), ($urandom_range(0, 3) == 0),
             21'($urandom()));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule